// File: doc/BRIEF.md
# 16-bit Carry-Lookahead Arithmetic Logic Unit

This block is a purely combinational 16-bit arithmetic logic unit assembled from four identical-style 4-bit slices. A 3-bit operation code is shared by every slice. It selects one of eight functions:
- three arithmetic functions: add, subtract B from A, and subtract A from B;
- three bitwise functions: exclusive-or, or, and and;
- two constant results: all zeros and all ones.

The three lower slices each report an active-low group generate and group propagate. A separate lookahead unit turns these signals and the global carry input into the carry-in of each upper slice, using sum-of-products terms. The carry does not ripple through the slices.

The most significant slice is a variant. Instead of group generate and propagate, it reports the final carry-out and a two's-complement overflow flag. The carry input is an ordinary add-in for all three arithmetic functions. A plain difference therefore needs the carry input held high, which completes the two's complement of the inverted operand.

Top module: `alu16_top`

## Requirements
- R1: With op code 3, `{cout_o, f_o}` equals `a_i + b_i + cin_i` as a 17-bit unsigned sum.
- R2: With op code 2, `{cout_o, f_o}` equals `a_i + ~b_i + cin_i`. With `cin_i` = 1 this is A minus B, and `cout_o` = 1 means no borrow.
- R3: With op code 1, `{cout_o, f_o}` equals `~a_i + b_i + cin_i`. With `cin_i` = 1 this is B minus A.
- R4: In op codes 1, 2 and 3, `ovr_o` is 1 exactly when the two addends, after any inversion, have equal sign bits (bit 15) and the sign of `f_o` differs from them. For example, 0x7FFF + 0x0001 gives 1, and 0x8000 - 0x0001 with `cin_i` = 1 gives 1.
- R5: Op code 4 gives `a_i ^ b_i`, op code 5 gives `a_i | b_i`, and op code 6 gives `a_i & b_i`.
- R6: Op code 0 gives `f_o` = 0x0000 and op code 7 gives `f_o` = 0xFFFF, whatever the values of `a_i`, `b_i` and `cin_i`.
- R7: In op codes 0, 4, 5, 6 and 7, `cout_o` and `ovr_o` are both 0.
- R8: The carry input propagates through all four slices in the same evaluation. 0xFFFF + 0x0000 + 1 gives 0x0000 with `cout_o` = 1, and 0x00FF + 0xFF00 + 1 gives 0x0000 with `cout_o` = 1.
- R9: In op codes 0 and 4 to 7, `f_o` does not depend on `cin_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| sel_i | input | 3 | Operation code; bit 0 is the least significant bit |
| cin_i | input | 1 | Carry into bit 0 |
| f_o | output | 16 | Function result |
| cout_o | output | 1 | Carry out of bit 15; 0 in the non-arithmetic codes |
| ovr_o | output | 1 | Two's-complement overflow; 0 in the non-arithmetic codes |

## Verification
The block holds no state, so any fault appears at the ports in the same evaluation as the inputs that expose it.

A wrong group generate or propagate, or a wrong lookahead term, corrupts the carry into one slice. This shows as a result that is off by one unit at nibble 4, 8 or 12, or as a wrong carry-out. Operand pairs whose carries run the whole length of the word expose such faults at once. Examples are all-ones plus a carry, and split halves of ones that propagate across the slice boundaries.

A wrong mode decode shows as a bitwise result in place of a sum, or as a nonzero carry-out or overflow flag in a bitwise code. Sweeping every code against the same operands catches this.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  // Operation codes; the numeric order is the select encoding seen at sel_i.
  typedef enum logic [2:0] {
    OP_ZERO  = 3'd0,
    OP_BSUBA = 3'd1,
    OP_ASUBB = 3'd2,
    OP_ADD   = 3'd3,
    OP_XOR   = 3'd4,
    OP_OR    = 3'd5,
    OP_AND   = 3'd6,
    OP_ONES  = 3'd7
  } alu_op_e;

  function automatic logic op_is_arith(input logic [2:0] op);
    return (op == OP_BSUBA) || (op == OP_ASUBB) || (op == OP_ADD);
  endfunction

endpackage

// File: rtl/alu16_slice.sv
// One W-bit slice. Lower slices report active-low group generate/propagate
// on aux_o = {gen_n, prop_n}; the most significant variant reports
// aux_o = {carry_out, overflow} instead.
module alu16_slice
  import alu16_pkg::*;
#(
  parameter int unsigned W      = 4,
  parameter bit          IS_MSB = 1'b0
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [2:0]   sel_i,
  input  logic         cin_i,
  output logic [W-1:0] f_o,
  output logic [1:0]   aux_o
);

  logic         arith;
  logic [W-1:0] opx;
  logic [W-1:0] opy;
  logic [W-1:0] bit_gen;
  logic [W-1:0] bit_tr;
  logic [W-1:0] half_sum;
  logic [W-1:0] chain;

  assign arith = op_is_arith(sel_i);

  // Operand conditioning: invert the subtrahend.
  always_comb begin
    opx = (sel_i == OP_BSUBA) ? ~a_i : a_i;
    opy = (sel_i == OP_ASUBB) ? ~b_i : b_i;
  end

  assign bit_gen  = opx & opy;
  assign bit_tr   = opx | opy;
  assign half_sum = opx ^ opy;

  // Carry into each bit position of this slice.
  always_comb begin
    chain[0] = cin_i;
    for (int i = 1; i < int'(W); i++) begin
      chain[i] = bit_gen[i-1] | (bit_tr[i-1] & chain[i-1]);
    end
  end

  always_comb begin
    unique case (sel_i)
      OP_BSUBA, OP_ASUBB, OP_ADD: f_o = half_sum ^ chain;
      OP_XOR:  f_o = a_i ^ b_i;
      OP_OR:   f_o = a_i | b_i;
      OP_AND:  f_o = a_i & b_i;
      OP_ONES: f_o = '1;
      default: f_o = '0;
    endcase
  end

  generate
    if (IS_MSB) begin : g_msb
      logic carry_top;
      assign carry_top = bit_gen[W-1] | (bit_tr[W-1] & chain[W-1]);
      assign aux_o[1]  = arith & carry_top;
      assign aux_o[0]  = arith & (carry_top ^ chain[W-1]);
    end else begin : g_grp
      logic grp_gen;
      logic grp_tr;
      always_comb begin
        grp_gen = 1'b0;
        for (int i = 0; i < int'(W); i++) begin
          grp_gen = bit_gen[i] | (bit_tr[i] & grp_gen);
        end
        grp_tr = &bit_tr;
      end
      // Active-low group signals, held inactive outside arithmetic codes.
      assign aux_o[1] = ~(arith & grp_gen);
      assign aux_o[0] = ~(arith & grp_tr);
    end
  endgenerate

endmodule

// File: rtl/alu16_cla.sv
// Lookahead unit: carry into slice k (k >= 1) as a flat sum of products over
// the group signals of slices 0..k-1 and the global carry input.
module alu16_cla #(
  parameter int unsigned N = 4
) (
  input  logic [N-2:0] gen_n_i,
  input  logic [N-2:0] prop_n_i,
  input  logic         cin_i,
  output logic [N-1:1] carry_o
);

  logic [N-2:0] gg;
  logic [N-2:0] pp;

  assign gg = ~gen_n_i;
  assign pp = ~prop_n_i;

  always_comb begin
    for (int k = 1; k < int'(N); k++) begin
      logic acc;
      logic term;
      // Term with the global carry input.
      term = cin_i;
      for (int m = 0; m < k; m++) term = term & pp[m];
      acc = term;
      // One term per generating slice j below k.
      for (int j = 0; j < k; j++) begin
        term = gg[j];
        for (int m = j + 1; m < k; m++) term = term & pp[m];
        acc = acc | term;
      end
      carry_o[k] = acc;
    end
  end

endmodule

// File: rtl/alu16_top.sv
module alu16_top #(
  parameter int unsigned SLICE_W  = 4,
  parameter int unsigned N_SLICES = 4
) (
  input  logic [SLICE_W*N_SLICES-1:0] a_i,
  input  logic [SLICE_W*N_SLICES-1:0] b_i,
  input  logic [2:0]                  sel_i,
  input  logic                        cin_i,
  output logic [SLICE_W*N_SLICES-1:0] f_o,
  output logic                        cout_o,
  output logic                        ovr_o
);

  localparam int unsigned WIDTH = SLICE_W * N_SLICES;

  logic [N_SLICES-1:0] slice_cin;
  logic [N_SLICES-2:0] grp_gen_n;
  logic [N_SLICES-2:0] grp_prop_n;
  logic [N_SLICES-1:1] la_carry;

  assign slice_cin[0] = cin_i;

  generate
    for (genvar s = 0; s < int'(N_SLICES); s++) begin : g_slice
      logic [1:0] aux;
      alu16_slice #(
        .W      (SLICE_W),
        .IS_MSB (s == int'(N_SLICES) - 1)
      ) slice_i (
        .a_i   (a_i[s*SLICE_W +: SLICE_W]),
        .b_i   (b_i[s*SLICE_W +: SLICE_W]),
        .sel_i (sel_i),
        .cin_i (slice_cin[s]),
        .f_o   (f_o[s*SLICE_W +: SLICE_W]),
        .aux_o (aux)
      );
      if (s == int'(N_SLICES) - 1) begin : g_top
        assign cout_o = aux[1];
        assign ovr_o  = aux[0];
      end else begin : g_low
        assign grp_gen_n[s]    = aux[1];
        assign grp_prop_n[s]   = aux[0];
        assign slice_cin[s+1]  = la_carry[s+1];
      end
    end
  endgenerate

  alu16_cla #(
    .N (N_SLICES)
  ) cla_i (
    .gen_n_i  (grp_gen_n),
    .prop_n_i (grp_prop_n),
    .cin_i    (cin_i),
    .carry_o  (la_carry)
  );

endmodule

// File: rtl/alu16_chk.sv
module alu16_chk #(
  parameter int unsigned SLICE_W  = 4,
  parameter int unsigned N_SLICES = 4
) (
  input logic [SLICE_W*N_SLICES-1:0] a_i,
  input logic [SLICE_W*N_SLICES-1:0] b_i,
  input logic [2:0]                  sel_i,
  input logic                        cin_i,
  input logic [SLICE_W*N_SLICES-1:0] f_o,
  input logic                        cout_o,
  input logic                        ovr_o
);

  localparam int unsigned WIDTH = SLICE_W * N_SLICES;

  logic [WIDTH:0]   wide;
  logic [WIDTH-1:0] ax;
  logic [WIDTH-1:0] by;
  logic             known;

  always_comb begin
    known = !$isunknown({a_i, b_i, sel_i, cin_i});
    ax    = (sel_i == 3'd1) ? ~a_i : a_i;
    by    = (sel_i == 3'd2) ? ~b_i : b_i;
    wide  = {1'b0, ax} + {1'b0, by} + {{WIDTH{1'b0}}, cin_i};
    if (known) begin
      if (sel_i == 3'd3) begin
        assert_add_R1: assert ({cout_o, f_o} == wide)
          else $error("R1 sum mismatch");
      end
      if (sel_i == 3'd2) begin
        assert_asubb_R2: assert ({cout_o, f_o} == wide)
          else $error("R2 difference mismatch");
      end
      if (sel_i == 3'd1) begin
        assert_bsuba_R3: assert ({cout_o, f_o} == wide)
          else $error("R3 difference mismatch");
      end
      if (sel_i inside {3'd1, 3'd2, 3'd3}) begin
        assert_ovr_R4: assert (ovr_o ==
          ((ax[WIDTH-1] == by[WIDTH-1]) && (f_o[WIDTH-1] != ax[WIDTH-1])))
          else $error("R4 overflow mismatch");
      end
      if (sel_i == 3'd4) begin
        assert_xor_R5: assert (f_o == (a_i ^ b_i)) else $error("R5 xor");
      end
      if (sel_i == 3'd5) begin
        assert_or_R5: assert (f_o == (a_i | b_i)) else $error("R5 or");
      end
      if (sel_i == 3'd6) begin
        assert_and_R5: assert (f_o == (a_i & b_i)) else $error("R5 and");
      end
      if (sel_i == 3'd0) begin
        assert_zero_R6: assert (f_o == '0) else $error("R6 zero");
      end
      if (sel_i == 3'd7) begin
        assert_ones_R6: assert (f_o == '1) else $error("R6 ones");
      end
      if (!(sel_i inside {3'd1, 3'd2, 3'd3})) begin
        assert_quiet_R7: assert (!cout_o && !ovr_o)
          else $error("R7 flags active in bitwise code");
      end
    end
  end

endmodule

bind alu16_top alu16_chk #(
  .SLICE_W  (SLICE_W),
  .N_SLICES (N_SLICES)
) chk_i (
  .a_i    (a_i),
  .b_i    (b_i),
  .sel_i  (sel_i),
  .cin_i  (cin_i),
  .f_o    (f_o),
  .cout_o (cout_o),
  .ovr_o  (ovr_o)
);

// File: tb/alu16_top_tb_top.sv
`timescale 1ns/1ps
module alu16_top_tb_top;

  logic        clk;
  logic        rst_n;
  logic [15:0] a, b, f;
  logic [2:0]  sel;
  logic        cin, cout, ovr;
  int          n_checks;
  int          n_fail;
  bit          done;

  alu16_top dut_i (
    .a_i(a), .b_i(b), .sel_i(sel), .cin_i(cin),
    .f_o(f), .cout_o(cout), .ovr_o(ovr)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [15:0] corner(input int i);
    logic [15:0] t [16] = '{16'h0000, 16'h0001, 16'h0002, 16'h7FFE,
                            16'h7FFF, 16'h8000, 16'h8001, 16'hFFFE,
                            16'hFFFF, 16'h00FF, 16'hFF00, 16'h0F0F,
                            16'hF0F0, 16'h5555, 16'hAAAA, 16'h0FFF};
    if (i < 16) return t[i];
    return 16'h0001 << (i - 16);
  endfunction

  // Returns {ovr, cout, f}.
  function automatic logic [17:0] model(input logic [2:0] s, input logic [15:0] x0,
                                        input logic [15:0] y0, input logic c);
    logic [15:0] x, y;
    logic [16:0] sum;
    logic        ov;
    x = x0; y = y0;
    case (s)
      3'd0: return {2'b00, 16'h0000};
      3'd4: return {2'b00, x0 ^ y0};
      3'd5: return {2'b00, x0 | y0};
      3'd6: return {2'b00, x0 & y0};
      3'd7: return {2'b00, 16'hFFFF};
      default: begin
        if (s == 3'd1) x = ~x0;
        if (s == 3'd2) y = ~y0;
        sum = 17'(x) + 17'(y) + 17'(c);
        ov  = (x[15] == y[15]) && (sum[15] != x[15]);
        return {ov, sum[16], sum[15:0]};
      end
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] s);
    case (s)
      3'd3: return "R1";
      3'd2: return "R2";
      3'd1: return "R3";
      3'd0, 3'd7: return "R6";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s sel=%0d a=%h b=%h cin=%0b actual=%h expected=%h",
               req, sel, a, b, cin, got, exp);
    end
  endtask

  task automatic drive(input logic [2:0] s, input logic [15:0] x, input logic [15:0] y,
                       input logic c);
    @(negedge clk);
    sel = s; a = x; b = y; cin = c;
    #2;
  endtask

  task automatic vec(input logic [2:0] s, input logic [15:0] x, input logic [15:0] y,
                     input logic c);
    logic [17:0] e;
    bit ar;
    drive(s, x, y, c);
    e  = model(s, x, y, c);
    ar = (s == 3'd1) || (s == 3'd2) || (s == 3'd3);
    check(req_of(s), f, e[15:0]);
    check(ar ? req_of(s) : "R7", {15'd0, cout}, {15'd0, e[16]});
    check(ar ? "R4" : "R7", {15'd0, ovr}, {15'd0, e[17]});
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    n_checks = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; a = '0; b = '0; sel = 3'd3; cin = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // Idle state with all-zero inputs (R1: 0 + 0 + 0).
    drive(3'd3, 16'h0000, 16'h0000, 1'b0);
    check("R1", f, 16'h0000);
    check("R1", {15'd0, cout}, 16'h0000);
    check("R4", {15'd0, ovr}, 16'h0000);
    // R4 corner cases.
    drive(3'd3, 16'h7FFF, 16'h0001, 1'b0);
    check("R4", f, 16'h8000);
    check("R4", {15'd0, ovr}, 16'h0001);
    drive(3'd2, 16'h8000, 16'h0001, 1'b1);
    check("R4", f, 16'h7FFF);
    check("R4", {15'd0, ovr}, 16'h0001);
    check("R2", {15'd0, cout}, 16'h0001);
    drive(3'd1, 16'h0005, 16'h0003, 1'b1);
    check("R3", f, 16'hFFFE);
    check("R3", {15'd0, cout}, 16'h0000);
    // R8: carry from cin across every slice boundary.
    drive(3'd3, 16'hFFFF, 16'h0000, 1'b1);
    check("R8", f, 16'h0000);
    check("R8", {15'd0, cout}, 16'h0001);
    drive(3'd3, 16'h00FF, 16'hFF00, 1'b1);
    check("R8", f, 16'h0000);
    check("R8", {15'd0, cout}, 16'h0001);
    drive(3'd3, 16'h0FFF, 16'h0000, 1'b1);
    check("R8", f, 16'h1000);
    // R9: bitwise and constant codes ignore cin.
    for (int s = 0; s < 8; s++) begin
      if (s >= 1 && s <= 3) continue;
      for (int k = 0; k < 8; k++) begin
        logic [15:0] x, y, f0;
        x = 16'($urandom); y = 16'($urandom);
        drive(3'(s), x, y, 1'b0);
        f0 = f;
        drive(3'(s), x, y, 1'b1);
        check("R9", f, f0);
      end
    end
    // Near-exhaustive sweep over corner operands.
    for (int s = 0; s < 8; s++)
      for (int c = 0; c < 2; c++)
        for (int i = 0; i < 32; i++)
          for (int j = 0; j < 32; j++)
            vec(3'(s), corner(i), corner(j), 1'(c));
    // Random operands.
    for (int k = 0; k < 2000; k++)
      vec(3'($urandom_range(7)), 16'($urandom), 16'($urandom), 1'($urandom));
    finish_run();
  end

endmodule